// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block burns one word of a one-time-programmable fuse array. A single-cycle start pulse brings in a word address, the data to burn and the timing field value. The block first strobes a read of the addressed word. It clears from the new data every bit that is already blown, so no fuse receives a second programming pulse. It then walks the remaining word from bit 0 upward. For each 1 it raises the program strobe with the bit index, and it skips each 0 in one cycle.

Every interval is counted in clock cycles taken from the timing value: the read strobe, the program strobe, and the settle gap that follows each strobe. After the last strobe the block stays busy for a fixed quiet period, so that no new fuse operation can begin too soon. It then raises done for one cycle. Address, data and timing are captured when the operation is accepted. Later changes on those inputs, and start pulses that arrive while the block is busy, have no effect on the word being burned. Software is expected to derive the timing fields from the clock rate.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, busy, done, the read strobe and the program strobe are all low.
- R2: When a start is accepted, the read strobe is high for the number of cycles given by timing bits [21:16], before any program strobe. The existing word is sampled in the last cycle of that strobe.
- R3: A program strobe is issued only for bits that are 1 in the new data and 0 in the existing word. After the operation the fuse word equals the old word OR the new data, and no bit is strobed twice.
- R4: Bits are programmed in ascending index order, one strobe per set bit, with the bit index presented on the bit output for the whole strobe.
- R5: Each program strobe lasts the number of cycles given by timing bits [11:0].
- R6: A settle gap of the number of cycles in timing bits [15:12] follows the read strobe and each program strobe. Each bit position up to the highest set bit costs one scan cycle, plus one final scan cycle. Busy therefore lasts read + gap + scans + set bits x (program + gap) + postamble cycles.
- R7: A timing field value of zero acts as one cycle.
- R8: The fuse address output holds the address captured at start for the whole operation, whatever the address input does meanwhile.
- R9: A start pulse while busy is ignored: it neither alters the operation in progress nor begins a second one.
- R10: If the masked data is zero, no program strobe is issued. The postamble still runs and done still pulses.
- R11: Busy stays high for POST_CYC cycles after the last scan cycle. Done then pulses high for exactly one cycle, in the first cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to burn one word |
| addr_i | input | ADDR_W | Fuse word address |
| data_i | input | DATA_W | Bits to burn (1 = blow) |
| timing_i | input | 22 | [11:0] program strobe, [15:12] settle gap, [21:16] read strobe, in cycles |
| rd_data_i | input | DATA_W | Current contents of the addressed fuse word |
| busy_o | output | 1 | Operation in progress, including the postamble |
| fuse_addr_o | output | ADDR_W | Captured word address to the fuse array |
| fuse_rd_stb_o | output | 1 | Read strobe to the fuse array |
| fuse_prog_stb_o | output | 1 | Program strobe for one bit |
| fuse_bit_o | output | $clog2(DATA_W) | Index of the bit being programmed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a 4-bit address and a 20-cycle postamble, so the quiet period can be measured exactly without long runs. A behavioural fuse array answers the read strobe and records each program strobe. The vectors cover the extremes of the timing fields: all zeros for the clamp, and the largest read and settle values. They also cover a data word whose only set bit is bit 31, which makes the scan run the full word length, and a word already fully blown, which leaves nothing to program.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // timing field positions: software packs these, the sequencer decodes them
  localparam int PROG_LSB  = 0;
  localparam int PROG_W    = 12;
  localparam int RELAX_LSB = 12;
  localparam int RELAX_W   = 4;
  localparam int READ_LSB  = 16;
  localparam int READ_W    = 6;
  localparam int TIM_W     = READ_LSB + READ_W;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_GAPR, S_SCAN, S_PROG, S_GAPP, S_POST
  } fps_state_e;

  // a zero field still yields one cycle
  function automatic logic [PROG_W-1:0] clamp_len(input logic [PROG_W-1:0] raw);
    return (raw == '0) ? PROG_W'(1) : raw;
  endfunction

  function automatic logic [PROG_W-1:0] prog_len(input logic [TIM_W-1:0] t);
    return clamp_len(t[PROG_LSB +: PROG_W]);
  endfunction

  function automatic logic [PROG_W-1:0] relax_len(input logic [TIM_W-1:0] t);
    return clamp_len(PROG_W'(t[RELAX_LSB +: RELAX_W]));
  endfunction

  function automatic logic [PROG_W-1:0] read_len(input logic [TIM_W-1:0] t);
    return clamp_len(PROG_W'(t[READ_LSB +: READ_W]));
  endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter never wraps upward on its own
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fps_shreg.sv
module fps_shreg #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              shift_i,
  output logic              lsb_o,
  output logic              empty_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= val_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign lsb_o   = sh_q[0];
  assign empty_o = (sh_q == '0);
  assign idx_o   = idx_q;

  // zero fill: a shift can only remove set bits, never add them
  p_shift_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> ($countones(sh_q) <= $countones($past(sh_q))));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int POST_CYC = 200,
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int POST_BW = $clog2(POST_CYC + 1),
  localparam int CNT_W   = (POST_BW > PROG_W) ? POST_BW : PROG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TIM_W-1:0]  timing_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  output logic              fuse_rd_stb_o,
  output logic              fuse_prog_stb_o,
  output logic [IDX_W-1:0]  fuse_bit_o,
  output logic              done_o
);
  fps_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [RELAX_LSB+RELAX_W-1:0] tim_q;
  logic              done_q;

  // named internal events
  logic              accept;
  logic              tmr_zero, tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              sh_load, sh_shift, sh_lsb, sh_empty;
  logic [DATA_W-1:0] masked;
  logic              post_end;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign masked   = data_q & ~rd_data_i;
  assign post_end = (state_q == S_POST) && tmr_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_READ;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(read_len(timing_i) - 1'b1);
      end
      S_READ: if (tmr_zero) begin
        state_d  = S_GAPR;
        sh_load  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(relax_len(TIM_W'(tim_q)) - 1'b1);
      end
      S_GAPR, S_GAPP: if (tmr_zero) state_d = S_SCAN;
      S_SCAN: begin
        tmr_load = 1'b1;
        if (sh_empty) begin
          state_d = S_POST;
          tmr_val = CNT_W'(POST_CYC - 1);
        end else if (sh_lsb) begin
          state_d = S_PROG;
          tmr_val = CNT_W'(prog_len(TIM_W'(tim_q)) - 1'b1);
        end else begin
          tmr_load = 1'b0;
          sh_shift = 1'b1;
        end
      end
      S_PROG: if (tmr_zero) begin
        state_d  = S_GAPP;
        sh_shift = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(relax_len(TIM_W'(tim_q)) - 1'b1);
      end
      S_POST: if (tmr_zero) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      tim_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= post_end;
      if (accept) begin
        addr_q <= addr_i;
        data_q <= data_i;
        tim_q  <= timing_i[RELAX_LSB+RELAX_W-1:0];
      end
    end
  end

  fps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  fps_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .val_i(masked),
    .shift_i(sh_shift), .lsb_o(sh_lsb), .empty_o(sh_empty), .idx_o(fuse_bit_o)
  );

  assign busy_o          = (state_q != S_IDLE);
  assign fuse_addr_o     = addr_q;
  assign fuse_rd_stb_o   = (state_q == S_READ);
  assign fuse_prog_stb_o = (state_q == S_PROG);
  assign done_o          = done_q;

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rd_stb_o && fuse_prog_stb_o));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_prog_stb_o && $past(fuse_prog_stb_o)) |-> $stable(fuse_bit_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !post_end) |=> busy_o);
endmodule

// File: tb/fuse_prog_seq_tb.sv
`timescale 1ns/1ps
module fuse_prog_seq_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int PC = 20;
  localparam int TW = 22;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] old;
    logic [DW-1:0] data;
    logic [TW-1:0] tim;
  } vec_t;

  function automatic logic [TW-1:0] mk_t(input int rd, input int rl, input int pg);
    return {6'(rd), 4'(rl), 12'(pg)};
  endfunction

  localparam vec_t VEC [6] = '{
    '{4'd1, 32'h0000_0000, 32'h0000_0001, {6'd3,  4'd2,  12'd5}},
    '{4'd2, 32'h0F0F_0000, 32'hFFFF_0003, {6'd2,  4'd1,  12'd4}},
    '{4'd3, 32'h0000_0000, 32'h8000_0000, {6'd1,  4'd3,  12'd2}},
    '{4'd4, 32'hFFFF_FFFF, 32'h1234_5678, {6'd4,  4'd2,  12'd6}},
    '{4'd5, 32'h0000_0000, 32'h0000_00A5, {6'd0,  4'd0,  12'd0}},
    '{4'd6, 32'h0000_00FF, 32'h0000_0F0F, {6'd63, 4'd15, 12'd20}}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [TW-1:0] tim = '0;
  logic [DW-1:0] rd_data;
  logic busy, rd_stb, prog_stb, done;
  logic [AW-1:0] faddr;
  logic [4:0] fbit;

  logic [DW-1:0] fuse_mem [16];
  int n_chk = 0, n_fail = 0;

  // monitor state, cleared by the bench before each operation
  int exp_rd, exp_pg, rd_run, pg_run, n_strobe, last_bit;
  int bad_width_rd, bad_width_pg, bad_order, reblow;
  bit rd_seen;

  always #5 clk = ~clk;

  assign rd_data = fuse_mem[faddr];

  fuse_prog_seq #(.DATA_W(DW), .ADDR_W(AW), .POST_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
    .timing_i(tim), .rd_data_i(rd_data), .busy_o(busy), .fuse_addr_o(faddr),
    .fuse_rd_stb_o(rd_stb), .fuse_prog_stb_o(prog_stb), .fuse_bit_o(fbit),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_busy(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                  input logic [TW-1:0] t);
    logic [DW-1:0] m;
    int msb, pop, scans;
    m = d & ~old;
    msb = -1; pop = 0;
    for (int i = 0; i < DW; i++) if (m[i]) begin msb = i; pop++; end
    scans = (m == 0) ? 1 : msb + 2;
    return len1(int'(t[21:16])) + len1(int'(t[15:12])) + scans +
           pop * (len1(int'(t[11:0])) + len1(int'(t[15:12]))) + PC;
  endfunction

  always @(negedge clk) begin
    if (rd_stb) rd_run++;
    else if (rd_run != 0) begin
      if (rd_run != exp_rd) bad_width_rd++;
      rd_seen = 1; rd_run = 0;
    end
    if (prog_stb) begin
      if (pg_run == 0) begin
        if (!rd_seen) bad_order++;
        if (n_strobe > 0 && int'(fbit) <= last_bit) bad_order++;
        if (fuse_mem[faddr][fbit]) reblow++;
        fuse_mem[faddr][fbit] = 1'b1;
        last_bit = int'(fbit);
        n_strobe++;
      end
      pg_run++;
    end else if (pg_run != 0) begin
      if (pg_run != exp_pg) bad_width_pg++;
      pg_run = 0;
    end
  end

  task automatic run_op(input vec_t v, input bit disturb);
    int cyc;
    logic [AW-1:0] other;
    other = ~v.addr;
    exp_rd = len1(int'(v.tim[21:16]));
    exp_pg = len1(int'(v.tim[11:0]));
    rd_run = 0; pg_run = 0; n_strobe = 0; last_bit = -1;
    bad_width_rd = 0; bad_width_pg = 0; bad_order = 0; reblow = 0; rd_seen = 0;
    fuse_mem[v.addr] = v.old;
    if (disturb) fuse_mem[other] = '0;
    @(negedge clk);
    start = 1; addr = v.addr; data = v.data; tim = v.tim;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (disturb && cyc == 3) begin
        addr = other; data = '1; start = 1;   // R8, R9 disturbance
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(done == 1'b1, "R11 done with busy low", done, 1);
    chk(cyc == exp_busy(v.old, v.data, v.tim), "R6 busy cycles", cyc,
        exp_busy(v.old, v.data, v.tim));
    chk(fuse_mem[v.addr] == (v.old | v.data), "R3 fuse word", fuse_mem[v.addr],
        v.old | v.data);
    chk(n_strobe == $countones(v.data & ~v.old), "R4 strobe count", n_strobe,
        $countones(v.data & ~v.old));
    chk(reblow == 0, "R3 no reblow", reblow, 0);
    chk(bad_order == 0, "R4 ascending order after read R2", bad_order, 0);
    chk(bad_width_rd == 0 && rd_seen, "R2 read strobe width", bad_width_rd, 0);
    chk(bad_width_pg == 0, "R5 program strobe width", bad_width_pg, 0);
    if (disturb) begin
      chk(fuse_mem[other] == '0, "R8 R9 other word untouched", fuse_mem[other], 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 done single cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) fuse_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_stb && !prog_stb, "R1 reset outputs",
        {busy, done, rd_stb, prog_stb}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !rd_stb && !prog_stb, "R1 idle after reset",
        {busy, done, rd_stb, prog_stb}, 0);

    // table walk: R7 via vector 4 (all zero fields), R10 via vector 3
    for (int k = 0; k < 6; k++) run_op(VEC[k], 1'b0);

    // R10: nothing left to blow, done still pulses
    chk(fuse_mem[4] == 32'hFFFF_FFFF, "R10 already blown word", fuse_mem[4], 32'hFFFF_FFFF);

    // R8 / R9: address change and second start mid-operation
    run_op('{4'd7, 32'h0, 32'h0000_0003, mk_t(2, 2, 3)}, 1'b1);

    // R7: zero fields again on a multi-bit word, after a live operation
    run_op('{4'd9, 32'h0000_0001, 32'h0000_0007, mk_t(0, 0, 0)}, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule